// File: doc/BRIEF.md
# Chess Aggressor Locator

This block answers one question of a hardware move generator. A victim square has already been chosen. Which piece of the side to move should capture on it next? The block sends a combined pattern outward from the target square. That pattern is made of queen rays, knight jumps, a king ring and pawn captures. Every square the pattern reaches that holds a matching friendly piece becomes a candidate origin.

Sliding rays travel square by square. They pass through empty squares and end at the first occupied square, so pieces further along a ray are never candidates. Candidates that the current ply has already tried are removed using a 64-bit exclusion mask. From the rest, the block picks the cheapest attacker. The search engine marks each returned origin in its mask and asks again, which walks through all the captures on one target in order of increasing attacker value.

A request is answered one clock later. The answer is either a valid flag with the 6-bit origin index, or a none flag when no unmasked attacker is left.

Top module: `aggr_locator`

## Requirements
- R1: Square index is rank*8+file, with file in bits [2:0]. Each square of `board_i` occupies the 4 bits at index*4. Within those 4 bits, bit 3 is the colour (0 white, 1 black) and bits [2:0] are the type: 0 empty, 1 pawn, 2 knight, 3 bishop, 4 rook, 5 queen, 6 king.
- R2: A request on `req_i` is answered on the next clock with exactly one of `hit_o` or `none_o` high, for one cycle. With no request, both flags are low. During reset, both flags are low.
- R3: A sliding ray crosses empty squares and stops at the first occupied square. Nothing behind that square qualifies, and no ray wraps across a board edge.
- R4: A piece reached along a diagonal qualifies if it is a bishop or a queen. A piece reached along a rank or file qualifies if it is a rook or a queen.
- R5: A knight qualifies from any of the eight knight offsets of the target that lie on the board.
- R6: A king qualifies only from the eight squares adjacent to the target.
- R7: A pawn qualifies only from the two diagonally adjacent squares one rank behind the target, as seen by the side to move. For white (`side_i`=0) that is rank-1. For black it is rank+1.
- R8: Only pieces whose colour equals `side_i` qualify.
- R9: Among the qualifying origins, the lowest type code wins (pawn < knight < bishop < rook < queen < king). Equal types go to the lowest square index.
- R10: An origin whose bit is set in `mask_i` is excluded. When no qualifying unmasked origin remains, the answer is `none_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request a search this cycle |
| board_i | input | 256 | 64 piece codes, square n at bits [4n+3:4n] |
| side_i | input | 1 | Side to move, 0 white, 1 black |
| target_i | input | 6 | Target square index |
| mask_i | input | 64 | Origins already tried in this ply |
| hit_o | output | 1 | An origin was found |
| none_o | output | 1 | No unmasked origin remains |
| origin_o | output | 6 | Chosen origin square, valid with hit_o |

## Verification
Some properties hold on every answer, and the assertions check these each cycle. The two flags are never high together. A flag only follows a request. A returned origin is never masked, never the target square, and always holds a piece of the side to move.

Other behaviour depends on board geometry and can only be shown by the bench scenarios. These are ray blocking, edge wrap, the pattern for each piece type, pawn direction, value priority, index tie-break, and the way successive masks step through several attackers.

// File: rtl/aggr_locator.sv
module aggr_locator #(
  parameter int EDGE = 8,
  parameter int PW   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_i,
  input  logic [EDGE*EDGE*PW-1:0]    board_i,
  input  logic                       side_i,
  input  logic [$clog2(EDGE*EDGE)-1:0] target_i,
  input  logic [EDGE*EDGE-1:0]       mask_i,
  output logic                       hit_o,
  output logic                       none_o,
  output logic [$clog2(EDGE*EDGE)-1:0] origin_o
);
  localparam int NSQ  = EDGE * EDGE;
  localparam int SQ_W = $clog2(NSQ);
  localparam int KW   = 3 + SQ_W;

  localparam logic [2:0] T_PAWN = 3'd1, T_KNIGHT = 3'd2, T_BISHOP = 3'd3,
                         T_ROOK = 3'd4, T_QUEEN  = 3'd5, T_KING   = 3'd6;

  localparam int RAY_F [8] = '{ 1,  1,  0, -1, -1, -1,  0,  1};
  localparam int RAY_R [8] = '{ 0,  1,  1,  1,  0, -1, -1, -1};
  localparam int JMP_F [8] = '{ 1,  2,  2,  1, -1, -2, -2, -1};
  localparam int JMP_R [8] = '{ 2,  1, -1, -2, -2, -1,  1,  2};

  function automatic logic on_board(int f, int r);
    return f >= 0 && f < EDGE && r >= 0 && r < EDGE;
  endfunction

  function automatic logic ray_fits(logic [2:0] t, int d, int k, logic side);
    logic diag;
    diag = RAY_F[d] != 0 && RAY_R[d] != 0;
    return (diag ? (t == T_BISHOP || t == T_QUEEN) : (t == T_ROOK || t == T_QUEEN))
        || (k == 1 && t == T_KING)
        || (k == 1 && diag && t == T_PAWN && RAY_R[d] == (side ? 1 : -1));
  endfunction

  logic [NSQ-1:0] cand;
  logic [KW-1:0]  best;
  logic           found;

  always_comb begin
    int tf, tr, f, r, s;
    logic blk;
    logic [PW-1:0] pc;
    tf = int'(target_i) % EDGE;
    tr = int'(target_i) / EDGE;
    f = 0; r = 0; s = 0; blk = 1'b0; pc = '0;
    cand = '0;
    for (int d = 0; d < 8; d++) begin
      blk = 1'b0;
      for (int k = 1; k < EDGE; k++) begin
        f = tf + RAY_F[d] * k;
        r = tr + RAY_R[d] * k;
        if (!blk && on_board(f, r)) begin
          s  = r * EDGE + f;
          pc = board_i[s*PW +: PW];
          if (pc[2:0] != 3'd0) begin
            blk = 1'b1;
            if (pc[3] == side_i && ray_fits(pc[2:0], d, k, side_i)) cand[s] = 1'b1;
          end
        end
      end
    end
    for (int j = 0; j < 8; j++) begin
      f = tf + JMP_F[j];
      r = tr + JMP_R[j];
      if (on_board(f, r)) begin
        s  = r * EDGE + f;
        pc = board_i[s*PW +: PW];
        if (pc[3] == side_i && pc[2:0] == T_KNIGHT) cand[s] = 1'b1;
      end
    end
  end

  always_comb begin
    logic [KW-1:0] key;
    best  = '1;
    found = 1'b0;
    key   = '0;
    for (int s = 0; s < NSQ; s++) begin
      key = {board_i[s*PW +: 3], SQ_W'(s)};
      if (cand[s] && !mask_i[s] && (!found || key < best)) begin
        best  = key;
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_o    <= 1'b0;
      none_o   <= 1'b0;
      origin_o <= '0;
    end else begin
      hit_o  <= req_i && found;
      none_o <= req_i && !found;
      if (req_i) origin_o <= found ? best[SQ_W-1:0] : '0;
    end
  end
endmodule

// File: rtl/aggr_locator_chk.sv
module aggr_locator_chk #(
  parameter int EDGE = 8,
  parameter int PW   = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         req_i,
  input logic [EDGE*EDGE*PW-1:0]      board_i,
  input logic                         side_i,
  input logic [$clog2(EDGE*EDGE)-1:0] target_i,
  input logic [EDGE*EDGE-1:0]         mask_i,
  input logic                         hit_o,
  input logic                         none_o,
  input logic [$clog2(EDGE*EDGE)-1:0] origin_o
);
  logic [EDGE*EDGE*PW-1:0]      board_q;
  logic [EDGE*EDGE-1:0]         mask_q;
  logic                         side_q;
  logic [$clog2(EDGE*EDGE)-1:0] tgt_q;

  always_ff @(posedge clk) begin
    board_q <= board_i;
    mask_q  <= mask_i;
    side_q  <= side_i;
    tgt_q   <= target_i;
  end

  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_o && none_o));

  assert_flag_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> (hit_o || none_o));

  assert_no_flag_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !(hit_o || none_o));

  assert_origin_unmasked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> !mask_q[origin_o]);

  assert_origin_own_piece_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (board_q[origin_o*PW + 3] == side_q && board_q[origin_o*PW +: 3] != 3'd0));

  assert_origin_not_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> origin_o != tgt_q);
endmodule

bind aggr_locator aggr_locator_chk #(.EDGE(EDGE), .PW(PW)) chk_i (.*);

// File: tb/aggr_locator_tb_top.sv
module aggr_locator_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_i = 1'b0;
  logic [255:0] board_i = '0;
  logic         side_i = 1'b0;
  logic [5:0]   target_i = '0;
  logic [63:0]  mask_i = '0;
  logic         hit_o, none_o;
  logic [5:0]   origin_o;

  always #5 clk = ~clk;

  aggr_locator dut_i (.*);

  typedef struct packed {
    logic [39:0] pcs;
    logic        side;
    logic [5:0]  tgt;
    logic [63:0] msk;
    logic        ev;
    logic [5:0]  eo;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{{6'd31,4'd4, 30'd0},                               1'b0, 6'd27, 64'd0, 1'b1, 6'd31}, // R4 rook on rank
    '{{6'd31,4'd4, 6'd29,4'd9, 20'd0},                   1'b0, 6'd27, 64'd0, 1'b0, 6'd0 }, // R3 blocked ray
    '{{6'd54,4'd3, 30'd0},                               1'b0, 6'd27, 64'd0, 1'b1, 6'd54}, // R4 bishop diag
    '{{6'd54,4'd4, 6'd31,4'd3, 20'd0},                   1'b0, 6'd27, 64'd0, 1'b0, 6'd0 }, // R4 wrong ray type
    '{{6'd44,4'd2, 30'd0},                               1'b0, 6'd27, 64'd0, 1'b1, 6'd44}, // R5 knight
    '{{6'd44,4'd2, 6'd10,4'd2, 20'd0},                   1'b0, 6'd27, 64'd0, 1'b1, 6'd10}, // R9 tie low index
    '{{6'd36,4'd6, 30'd0},                               1'b0, 6'd27, 64'd0, 1'b1, 6'd36}, // R6 king adjacent
    '{{6'd45,4'd6, 30'd0},                               1'b0, 6'd27, 64'd0, 1'b0, 6'd0 }, // R6 king too far
    '{{6'd18,4'd1, 30'd0},                               1'b0, 6'd27, 64'd0, 1'b1, 6'd18}, // R7 white pawn behind
    '{{6'd34,4'd1, 30'd0},                               1'b0, 6'd27, 64'd0, 1'b0, 6'd0 }, // R7 white pawn ahead
    '{{6'd34,4'd9, 30'd0},                               1'b1, 6'd27, 64'd0, 1'b1, 6'd34}, // R7 black pawn
    '{{6'd26,4'd1, 30'd0},                               1'b0, 6'd27, 64'd0, 1'b0, 6'd0 }, // R7 pawn beside
    '{{6'd31,4'd13, 30'd0},                              1'b0, 6'd27, 64'd0, 1'b0, 6'd0 }, // R8 enemy queen
    '{{6'd31,4'd13, 30'd0},                              1'b1, 6'd27, 64'd0, 1'b1, 6'd31}, // R8 black to move
    '{{6'd31,4'd5, 6'd44,4'd2, 6'd24,4'd4, 10'd0},       1'b0, 6'd27, 64'd0, 1'b1, 6'd44}, // R9 value order
    '{{6'd31,4'd5, 6'd44,4'd2, 6'd24,4'd4, 10'd0},       1'b0, 6'd27, 64'd1<<44, 1'b1, 6'd24}, // R10 mask one
    '{{6'd31,4'd5, 6'd44,4'd2, 6'd24,4'd4, 10'd0},       1'b0, 6'd27, (64'd1<<44)|(64'd1<<24), 1'b1, 6'd31}, // R10
    '{{6'd31,4'd5, 6'd44,4'd2, 6'd24,4'd4, 10'd0},       1'b0, 6'd27, (64'd1<<44)|(64'd1<<24)|(64'd1<<31), 1'b0, 6'd0}, // R10 none
    '{{6'd8,4'd4, 30'd0},                                1'b0, 6'd7,  64'd0, 1'b0, 6'd0 }, // R3 no edge wrap
    '{{6'd15,4'd2, 30'd0},                               1'b0, 6'd0,  64'd0, 1'b0, 6'd0 }, // R5 no knight wrap
    '{{6'd0,4'd5, 30'd0},                                1'b0, 6'd27, 64'd0, 1'b1, 6'd0 }, // R3 long diag ray
    '{{6'd0,4'd5, 6'd9,4'd0, 6'd18,4'd10, 10'd0},         1'b0, 6'd27, 64'd0, 1'b0, 6'd0 }  // R3 blocked by enemy knight
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(string req, logic h, logic n, logic [5:0] o,
                       logic eh, logic en, logic [5:0] eo);
    checks++;
    if (h !== eh || n !== en || (eh && o !== eo)) begin
      fails++;
      $display("FAIL %s: got hit=%b none=%b origin=%0d, expected hit=%b none=%b origin=%0d",
               req, h, n, o, eh, en, eo);
    end
  endtask

  task automatic apply(vec_t v);
    logic [9:0] slot;
    board_i = '0;
    for (int i = 0; i < 4; i++) begin
      slot = v.pcs[39 - i*10 -: 10];
      if (slot[3:0] != 4'd0) board_i[slot[9:4]*4 +: 4] = slot[3:0];
    end
    side_i   = v.side;
    target_i = v.tgt;
    mask_i   = v.msk;
    req_i    = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R2 reset", hit_o, none_o, origin_o, 1'b0, 1'b0, 6'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 idle", hit_o, none_o, origin_o, 1'b0, 1'b0, 6'd0);
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check($sformatf("R1/vector %0d", i), hit_o, none_o, origin_o,
            VEC[i].ev, !VEC[i].ev, VEC[i].eo);
    end
    @(negedge clk);
    check("R2 flags drop", hit_o, none_o, origin_o, 1'b0, 1'b0, 6'd0);
    apply(VEC[0]);
    apply(VEC[1]);
    check("R2 back-to-back", hit_o, none_o, origin_o, 1'b0, 1'b1, 6'd0);
    req_i = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    check("R2 reset clears", hit_o, none_o, origin_o, 1'b0, 1'b0, 6'd0);
    req_i = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule